// File: doc/BRIEF.md
# Processor-attached serial transceiver

This block is a small asynchronous serial port that sits on a simple processor bus. A processor writes a byte into a one-byte transmit buffer. The transmitter sends it on `txd` as one start bit, eight data bits with the least significant bit first, an optional parity bit and one stop bit. The receiver watches `rxd` through a two-stage synchronizer and finds the start of each frame. It checks the start bit again at its midpoint and samples every later bit at its centre. It then holds the byte for the processor to read, together with framing and parity status.

All timing comes from one sampling tick at sixteen times the bit rate. A down-counter produces the tick by dividing the system clock. The processor can load the divisor at run time, so one build can run at 4800 or 9600 bit/s from different input clocks. One tick lasts divisor+1 clock cycles, and one bit lasts sixteen ticks. The `par_mode` pin selects parity: 0 is none, 1 is even, 2 is odd and 3 behaves as none. The mode is captured when a frame starts.

The bus has no stream handshake. A transfer takes place on each clock edge where `cs` is high. `rd_wr` high means a read and low means a write. Flow control is done by the processor polling the two flags: it writes only while `tx_ready` is high and reads only while `rx_avail` is high. A write to the transmit buffer while `tx_ready` is low is dropped.

Top module: `sio_port`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1, `rx_avail` is 0 and a status read returns 0x01.
- R2: A transmitted frame is a 0 start bit, then the eight data bits least significant bit first, then a 1 stop bit. Each bit lasts 16*(divisor+1) clock cycles, and `txd` is 1 whenever nothing is being sent.
- R3: With even parity the parity bit makes the count of ones over data and parity even. With odd parity it makes that count odd. With `par_mode` 0 or 3 no parity bit is sent or expected.
- R4: A write to address 0 clears `tx_ready` on the next edge. `tx_ready` stays 0 until that frame's stop bit has been sent. A write to address 0 while `tx_ready` is 0 is ignored and sends no frame.
- R5: A received frame sets `rx_avail` and holds the byte. A read at address 0 returns that byte and clears `rx_avail`.
- R6: A low pulse on `rxd` that has ended before the middle of the start bit is treated as noise. It does not set `rx_avail`.
- R7: A stop bit sampled low sets status bit 2 for that frame. The byte is still stored.
- R8: A received parity bit that does not match the selected mode sets status bit 3 for that frame.
- R9: A write to address 2 sets divisor bits 7:0. A write to address 3 sets bits 15:8 and restarts the tick counter with the new value. The bit time then follows the new divisor.
- R10: `dout_en` is 1 only in cycles with `cs` high and `rd_wr` high. At all other times `dout` is 0.
- R11: A read at address 1 returns `tx_ready` in bit 0, `rx_avail` in bit 1, the framing flag in bit 2, the parity flag in bit 3, and zeros in bits 7:4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select; one transfer per edge while high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Register address: 0 data, 1 status, 2 divisor low, 3 divisor high |
| din | input | 8 | Write data from processor |
| dout | output | 8 | Read data to processor, 0 when not driven |
| dout_en | output | 1 | Output enable for the shared data bus |
| par_mode | input | 2 | Parity: 0 none, 1 even, 2 odd, 3 none |
| tx_ready | output | 1 | Transmit buffer empty and accepting a byte |
| rx_avail | output | 1 | Received byte waiting to be read |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The bench writes a second byte while a frame is still going out. A transmitter that accepted it would corrupt the frame in flight or send an extra frame, and the scoreboard would find no expected item for it. A divisor change that did not restart the counter, or did not change the bit time, would make the monitor sample at the wrong bit centres. A short low glitch on `rxd` checks the midpoint re-check of the start bit; without it a phantom byte of all ones would appear. A forced low stop bit and a flipped parity bit check that each error flag is raised only for its own fault and that the byte is still delivered.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W = 8;
  localparam int OSR    = 16;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DLO  = 2'd2;
  localparam logic [1:0] A_DHI  = 2'd3;

  typedef enum logic [1:0] {PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2, PAR_OFF = 2'd3} par_e;
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} frm_e;

  function automatic logic has_par(input par_e m);
    return (m == PAR_EVEN) || (m == PAR_ODD);
  endfunction

  function automatic logic par_bit(input logic [DATA_W-1:0] d, input par_e m);
    return (^d) ^ (m == PAR_ODD);
  endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV_W = 16,
  parameter logic [DIV_W-1:0] DEF_DIV = 16'd324
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] din,
  output logic       tick
);
  localparam int HI_W = DIV_W - 8;
  logic [DIV_W-1:0] div_q, cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DEF_DIV;
      cnt_q <= DEF_DIV;
    end else begin
      if (wr_lo) div_q[7:0] <= din;
      if (wr_hi) begin
        div_q[DIV_W-1:8] <= din[HI_W-1:0];
        cnt_q            <= {din[HI_W-1:0], div_q[7:0]};
      end else if (cnt_q == '0) begin
        cnt_q <= div_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int NB = DATA_W,
  parameter int OS = OSR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [NB-1:0] data,
  input  logic [1:0]    par_mode,
  output logic          ready,
  output logic          txd
);
  localparam int CW = $clog2(OS);
  localparam int IW = $clog2(NB);
  localparam logic [CW-1:0] CLAST = CW'(OS - 1);
  localparam logic [IW-1:0] ILAST = IW'(NB - 1);

  frm_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [NB-1:0] sh_q;
  logic          pbit_q, pend_q;
  par_e          mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
      pend_q <= 1'b0;
      mode_q <= PAR_NONE;
    end else begin
      if (load && ready) begin
        sh_q   <= data;
        mode_q <= par_e'(par_mode);
        pbit_q <= par_bit(data, par_e'(par_mode));
        pend_q <= 1'b1;
      end
      if (tick) begin
        if (st_q == S_IDLE) begin
          if (pend_q) begin
            st_q   <= S_START;
            cnt_q  <= '0;
            pend_q <= 1'b0;
          end
        end else if (cnt_q != CLAST) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          case (st_q)
            S_START: begin st_q <= S_DATA; idx_q <= '0; end
            S_DATA: begin
              sh_q <= sh_q >> 1;
              if (idx_q == ILAST) st_q <= has_par(mode_q) ? S_PAR : S_STOP;
              else idx_q <= idx_q + 1'b1;
            end
            S_PAR:   st_q <= S_STOP;
            default: st_q <= S_IDLE;
          endcase
        end
      end
    end
  end

  assign ready = (st_q == S_IDLE) && !pend_q;

  always_comb begin
    case (st_q)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh_q[0];
      S_PAR:   txd = pbit_q;
      default: txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int NB = DATA_W,
  parameter int OS = OSR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic [1:0]    par_mode,
  output logic          done,
  output logic [NB-1:0] byte_o,
  output logic          ferr,
  output logic          perr
);
  localparam int CW = $clog2(OS);
  localparam int IW = $clog2(NB);
  localparam logic [CW-1:0] CLAST = CW'(OS - 1);
  localparam logic [CW-1:0] CHALF = CW'(OS / 2 - 1);
  localparam logic [IW-1:0] ILAST = IW'(NB - 1);

  logic [1:0]    sync_q;
  logic          rxs;
  frm_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [NB-1:0] sh_q;
  logic          rpar_q;
  par_e          mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end
  assign rxs = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      rpar_q <= 1'b0;
      mode_q <= PAR_NONE;
      done   <= 1'b0;
      byte_o <= '0;
      ferr   <= 1'b0;
      perr   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st_q)
          S_IDLE: if (!rxs) begin
            st_q   <= S_START;
            cnt_q  <= '0;
            mode_q <= par_e'(par_mode);
          end
          S_START: begin
            if (cnt_q != CHALF) cnt_q <= cnt_q + 1'b1;
            else if (rxs) st_q <= S_IDLE;
            else begin st_q <= S_DATA; cnt_q <= '0; idx_q <= '0; end
          end
          default: begin
            if (cnt_q != CLAST) cnt_q <= cnt_q + 1'b1;
            else begin
              cnt_q <= '0;
              case (st_q)
                S_DATA: begin
                  sh_q <= {rxs, sh_q[NB-1:1]};
                  if (idx_q == ILAST) st_q <= has_par(mode_q) ? S_PAR : S_STOP;
                  else idx_q <= idx_q + 1'b1;
                end
                S_PAR: begin rpar_q <= rxs; st_q <= S_STOP; end
                default: begin
                  st_q   <= S_IDLE;
                  done   <= 1'b1;
                  byte_o <= sh_q;
                  ferr   <= !rxs;
                  perr   <= has_par(mode_q) && (rpar_q != par_bit(sh_q, mode_q));
                end
              endcase
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter logic [DIV_W-1:0] DEF_DIV = 16'd324
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs,
  input  logic        rd_wr,
  input  logic [1:0]  addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        dout_en,
  input  logic [1:0]  par_mode,
  output logic        tx_ready,
  output logic        rx_avail,
  output logic        txd,
  input  logic        rxd
);
  logic wr, rd, tick, rx_done, rx_ferr, rx_perr;
  logic [DATA_W-1:0] rx_byte, rx_buf;
  logic ferr_q, perr_q;

  assign wr = cs && !rd_wr;
  assign rd = cs && rd_wr;

  sio_baud #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_baud (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(wr && addr == A_DLO), .wr_hi(wr && addr == A_DHI),
    .din(din), .tick(tick)
  );

  sio_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(wr && addr == A_DATA), .data(din), .par_mode(par_mode),
    .ready(tx_ready), .txd(txd)
  );

  sio_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_mode(par_mode),
    .done(rx_done), .byte_o(rx_byte), .ferr(rx_ferr), .perr(rx_perr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf   <= '0;
      rx_avail <= 1'b0;
      ferr_q   <= 1'b0;
      perr_q   <= 1'b0;
    end else if (rx_done) begin
      rx_buf   <= rx_byte;
      rx_avail <= 1'b1;
      ferr_q   <= rx_ferr;
      perr_q   <= rx_perr;
    end else if (rd && addr == A_DATA) begin
      rx_avail <= 1'b0;
    end
  end

  always_comb begin
    dout = '0;
    if (rd) begin
      case (addr)
        A_DATA:  dout = rx_buf;
        A_STAT:  dout = {4'b0, perr_q, ferr_q, rx_avail, tx_ready};
        default: dout = '0;
      endcase
    end
  end
  assign dout_en = rd;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       rd_wr,
  input logic [1:0] addr,
  input logic [7:0] dout,
  input logic       dout_en,
  input logic       tx_ready,
  input logic       txd,
  input logic       tick
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  p_tbr_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !rd_wr && addr == 2'd0 && tx_ready) |=> !tx_ready);

  p_bit_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(tick));

  p_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd_wr) |-> (!dout_en && dout == 8'h00));

  p_stat_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd_wr && addr == 2'd1) |-> (dout[7:4] == 4'h0 && dout[0] == tx_ready));
endmodule

bind sio_port sio_port_chk u_chk (.*);

// File: tb/sim_sio_port.sv
`timescale 1ns/1ps
module sim_sio_port;
  logic clk = 0, rst_n = 0, cs = 0, rd_wr = 0, rxd = 1;
  logic [1:0] addr = 0, par_mode = 0;
  logic [7:0] din = 0, dout;
  logic dout_en, tx_ready, rx_avail, txd;

  always #5 clk = ~clk;

  sio_port u0 (.clk(clk), .rst_n(rst_n), .cs(cs), .rd_wr(rd_wr), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en), .par_mode(par_mode),
    .tx_ready(tx_ready), .rx_avail(rx_avail), .txd(txd), .rxd(rxd));

  int n_chk = 0, n_bad = 0, tx_frames = 0, div_cur = 324;
  logic [9:0] txq[$];
  bit finished = 0;

  function automatic int bitc();
    return 16 * (div_cur + 1);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] m);
    return (^d) ^ (m == 2'd2);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1; rd_wr = 0; addr = a; din = d;
    #2;
    check(!dout_en && dout == 0, "R10 write cycle", {dout_en, dout}, 0);
    @(negedge clk);
    cs = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd_wr = 1; addr = a;
    #2;
    d = dout;
    check(dout_en, "R10 read enable", dout_en, 1);
    @(negedge clk);
    cs = 0; rd_wr = 0;
  endtask

  task automatic send_tx(input logic [7:0] d);
    txq.push_back({par_mode, d});
    bus_wr(2'd0, d);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 20000 && !tx_ready; i++) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit flip_par, input bit bad_stop);
    int b = bitc();
    rxd = 0; repeat (b) @(posedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (b) @(posedge clk); end
    if (par_mode == 2'd1 || par_mode == 2'd2) begin
      rxd = exp_par(d, par_mode) ^ flip_par; repeat (b) @(posedge clk);
    end
    if (bad_stop) begin
      rxd = 0; repeat (b / 16 * 11) @(posedge clk);
      rxd = 1; repeat (b - b / 16 * 11) @(posedge clk);
    end else begin
      rxd = 1; repeat (b) @(posedge clk);
    end
    repeat (b) @(posedge clk);
  endtask

  task automatic rx_case(input logic [7:0] d, input bit fp, input bit bs, input string tag);
    logic [7:0] s, r;
    send_rx(d, fp, bs);
    bus_rd(2'd1, s);
    check(s == {4'b0, fp, bs, 2'b11}, {tag, " status"}, s, {4'b0, fp, bs, 2'b11});
    bus_rd(2'd0, r);
    check(r == d, {tag, " R5 data"}, r, d);
    bus_rd(2'd1, s);
    check(s[1] == 0, {tag, " R5 cleared"}, s[1], 0);
  endtask

  // monitor: decodes txd frames and compares with the scoreboard queue
  initial begin
    wait (rst_n);
    forever begin
      logic [7:0] got;
      logic [9:0] exp;
      logic [1:0] m;
      int b;
      @(negedge txd);
      b = bitc();
      repeat (b / 2) @(posedge clk); #1;
      check(txd == 0, "R2 start bit", txd, 0);
      for (int i = 0; i < 8; i++) begin repeat (b) @(posedge clk); #1; got[i] = txd; end
      tx_frames++;
      if (txq.size() == 0) begin
        check(0, "R4 unexpected frame", got, 0);
        exp = {2'd0, got};
      end else exp = txq.pop_front();
      m = exp[9:8];
      check(got == exp[7:0], "R2 data", got, exp[7:0]);
      if (m == 2'd1 || m == 2'd2) begin
        repeat (b) @(posedge clk); #1;
        check(txd == exp_par(exp[7:0], m), "R3 parity bit", txd, exp_par(exp[7:0], m));
      end
      repeat (b) @(posedge clk); #1;
      check(txd == 1, "R2 stop bit", txd, 1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(txd == 1 && tx_ready == 1 && rx_avail == 0, "R1 reset pins", {txd, tx_ready, rx_avail}, 3'b110);
    check(!dout_en && dout == 0, "R10 idle bus", {dout_en, dout}, 0);
    bus_rd(2'd1, s);
    check(s == 8'h01, "R1 R11 reset status", s, 8'h01);

    bus_wr(2'd2, 8'd3); bus_wr(2'd3, 8'd0); div_cur = 3;  // R9 divisor 3

    par_mode = 2'd0;
    send_tx(8'hA5);
    bus_rd(2'd1, s);
    check(s[0] == 0, "R4 ready cleared", s[0], 0);
    bus_wr(2'd0, 8'h3C);  // ignored while busy
    wait_ready();
    repeat (2 * bitc()) @(posedge clk);
    check(tx_frames == 1, "R4 busy write ignored", tx_frames, 1);

    par_mode = 2'd1; send_tx(8'h07); wait_ready();   // R3 even
    par_mode = 2'd2; send_tx(8'h07); wait_ready();   // R3 odd
    send_tx(8'h00); wait_ready();
    par_mode = 2'd3; send_tx(8'hF0); wait_ready();   // R3 mode 3 no parity
    repeat (bitc()) @(posedge clk);

    bus_wr(2'd2, 8'd1); bus_wr(2'd3, 8'd0); div_cur = 1;  // R9 new rate
    par_mode = 2'd0; send_tx(8'h81); wait_ready();
    repeat (bitc()) @(posedge clk);
    check(tx_frames == 6 && txq.size() == 0, "R9 frames at new rate", tx_frames, 6);

    rx_case(8'h5A, 0, 0, "R5 none");
    par_mode = 2'd1; rx_case(8'h96, 0, 0, "R3 even rx");
    par_mode = 2'd2; rx_case(8'h3B, 1, 0, "R8 parity error");
    rx_case(8'hC4, 0, 0, "R8 flag clears");
    par_mode = 2'd0; rx_case(8'h12, 0, 1, "R7 framing error");
    rx_case(8'hE1, 0, 0, "R7 flag clears");

    rxd = 0; repeat (3 * (div_cur + 1)) @(posedge clk);  // R6 glitch
    rxd = 1; repeat (14 * bitc()) @(posedge clk);
    bus_rd(2'd1, s);
    check(s[1] == 0, "R6 glitch rejected", s[1], 0);
    check(txq.size() == 0, "R2 scoreboard drained", txq.size(), 0);

    summary();
  end
endmodule